// File: doc/BRIEF.md
# Distributed Per-Bank Refresh Scheduler

This block spreads refresh operations evenly over every bank of one memory channel. Instead of refreshing all banks together at a fixed tick, it earns one refresh credit each time a system interval elapses. That interval is the per-bank refresh period divided by the number of banks in the channel. Earned credits build up in a backlog counter. A round-robin target pointer names the one bank that is due next. A refresh goes to that bank only, and only when the bank, the shared command/data path and the bank's rank all have room for it.

The surrounding controller supplies a busy flag per bank, a path-idle flag and a flag per rank that says whether another activate fits in the rank's four-activate window. In the same cycle as the refresh strobe, the controller loads the refreshed bank's busy counter with the bank busy time. It also sets its three path counters to the basic path busy time and records an activate for the reported rank.

When the enable input is low, the interval countdown is frozen, as it is for a fixed-latency operating mode, so no credits accrue. Credits already owed can still be issued while enable is low. If the backlog reaches its limit, the block raises a sticky overrun error.

Top module: `refresh_sched`

## Requirements
- R1: After reset the backlog is 0, the target pointer is bank 0, the overrun flag is low and the countdown holds 1, so the first enabled cycle earns a credit that can be issued in that same cycle to bank 0.
- R2: While enabled, the countdown decrements once per cycle. When it would reach zero it reloads with INTERVAL = REFRESH_PERIOD / (NUM_RANKS*BANKS_PER_RANK) and earns one credit, which gives exactly one credit per INTERVAL enabled cycles.
- R3: While `enable` is low, the countdown holds its value and no credit is earned, so with an empty backlog no strobe occurs. A backlog left over from before can still be issued.
- R4: `ref_fire` is asserted only when the backlog is nonzero or a credit is earned in the same cycle.
- R5: No refresh is issued while the targeted bank's `bank_busy` bit is high. No other bank is tried in its place.
- R6: No refresh is issued while `path_idle` is low.
- R7: No refresh is issued while `act_room` is low for the rank of the targeted bank, where the rank is bank / BANKS_PER_RANK.
- R8: Each strobe lowers the backlog by one and advances the pointer by one, and the pointer wraps from NUM_BANKS-1 to 0. Without a strobe the pointer holds.
- R9: When the backlog reaches 10 (OVERRUN_LIMIT), the backlog saturates there and `overrun` goes high in the next cycle. It stays high until reset.
- R10: During a strobe, `ref_bank` gives the target bank, `ref_rank` gives its rank, and `ref_sel` is one-hot with bit `ref_bank` set. With no strobe, `ref_sel` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Lets the interval countdown run |
| bank_busy | input | NUM_BANKS | Per-bank busy flag from the bank busy counters |
| path_idle | input | 1 | High when the basic path busy counter is zero |
| act_room | input | NUM_RANKS | Per-rank flag: rank is below its four-activate limit |
| ref_fire | output | 1 | Refresh strobe for this cycle |
| ref_bank | output | BANK_W | Bank being refreshed |
| ref_rank | output | RANK_W | Rank of the bank being refreshed |
| ref_sel | output | NUM_BANKS | One-hot bank select of the strobe |
| overrun | output | 1 | Sticky flag: refresh backlog reached its limit |

## Verification
A free-running stretch with every resource available shows one strobe per interval, with the pointer walking through the banks and wrapping. A disabled stretch shows whether the countdown really freezes. A long blocked-path stretch builds the backlog up to its limit, which separates correct saturation and the sticky error from a counter that wraps. Seeded random busy, path and activate-room patterns then separate the three blocking conditions from one another. They also show whether a busy target wrongly lets another bank go first.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  // Index width that never collapses to zero bits.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width that holds the value n itself.
  function automatic int unsigned val_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/refsch_interval_timer.sv
module refsch_interval_timer
  import refsch_pkg::*;
#(
  parameter int unsigned INTERVAL = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic credit
);
  localparam int unsigned CNT_W = val_w(INTERVAL);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_one;

  assign at_one = (cnt_q == CNT_W'(1));
  assign credit = enable && at_one;

  always_comb begin
    cnt_d = cnt_q;
    if (enable) begin
      if (at_one) cnt_d = CNT_W'(INTERVAL);
      else        cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(1);
    else        cnt_q <= cnt_d;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && (cnt_q <= CNT_W'(INTERVAL)));
  // R3
  cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(cnt_q));
endmodule

// File: rtl/refsch_backlog.sv
module refsch_backlog
  import refsch_pkg::*;
#(
  parameter int unsigned OVERRUN_LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic credit,
  input  logic take,
  output logic avail,
  output logic overrun
);
  localparam int unsigned PEND_W = val_w(OVERRUN_LIMIT);

  logic [PEND_W-1:0] pend_q, pend_d;
  logic [PEND_W:0]   sum;
  logic              ovf_q, ovf_d;

  assign avail   = (pend_q != '0) || credit;
  assign overrun = ovf_q;

  always_comb begin
    sum   = {1'b0, pend_q} + (PEND_W+1)'(credit) - (PEND_W+1)'(take);
    ovf_d = ovf_q;
    if (sum >= (PEND_W+1)'(OVERRUN_LIMIT)) begin
      pend_d = PEND_W'(OVERRUN_LIMIT);
      ovf_d  = 1'b1;
    end else begin
      pend_d = PEND_W'(sum);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  // R4
  take_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((pend_q != '0) || credit));
  // R9
  pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PEND_W'(OVERRUN_LIMIT));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R8
  pend_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !credit) |=> (pend_q == $past(pend_q) - PEND_W'(1)));
endmodule

// File: rtl/refsch_target_ptr.sv
module refsch_target_ptr
  import refsch_pkg::*;
#(
  parameter int unsigned NUM_BANKS      = 8,
  parameter int unsigned BANKS_PER_RANK = 4,
  parameter int unsigned NUM_RANKS      = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             advance,
  output logic [idx_w(NUM_BANKS)-1:0]      bank,
  output logic [idx_w(NUM_RANKS)-1:0]      rank,
  output logic [NUM_BANKS-1:0]             sel
);
  localparam int unsigned BANK_W = idx_w(NUM_BANKS);
  localparam int unsigned RANK_W = idx_w(NUM_RANKS);
  localparam logic [BANK_W-1:0] LAST = BANK_W'(NUM_BANKS - 1);

  logic [BANK_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (advance) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + BANK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign bank = ptr_q;
  assign rank = RANK_W'(int'(ptr_q) / int'(BANKS_PER_RANK));

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
    assign sel[g] = advance && (ptr_q == BANK_W'(g));
  end

  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && ptr_q == LAST) |=> (ptr_q == '0));
  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(ptr_q));
  // R8
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsch_pkg::*;
#(
  parameter int unsigned NUM_RANKS      = 2,
  parameter int unsigned BANKS_PER_RANK = 4,
  parameter int unsigned REFRESH_PERIOD = 160,
  parameter int unsigned OVERRUN_LIMIT  = 10,
  localparam int unsigned NUM_BANKS     = NUM_RANKS * BANKS_PER_RANK,
  localparam int unsigned BANK_W        = idx_w(NUM_BANKS),
  localparam int unsigned RANK_W        = idx_w(NUM_RANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [NUM_BANKS-1:0] bank_busy,
  input  logic                 path_idle,
  input  logic [NUM_RANKS-1:0] act_room,
  output logic                 ref_fire,
  output logic [BANK_W-1:0]    ref_bank,
  output logic [RANK_W-1:0]    ref_rank,
  output logic [NUM_BANKS-1:0] ref_sel,
  output logic                 overrun
);
  localparam int unsigned INTERVAL = REFRESH_PERIOD / NUM_BANKS;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic credit, avail;
  logic target_free;

  refsch_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .enable (enable),
    .credit (credit)
  );

  refsch_backlog #(.OVERRUN_LIMIT(OVERRUN_LIMIT)) u_backlog (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .credit  (credit),
    .take    (ref_fire),
    .avail   (avail),
    .overrun (overrun)
  );

  refsch_target_ptr #(
    .NUM_BANKS      (NUM_BANKS),
    .BANKS_PER_RANK (BANKS_PER_RANK),
    .NUM_RANKS      (NUM_RANKS)
  ) u_ptr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .advance (ref_fire),
    .bank    (ref_bank),
    .rank    (ref_rank),
    .sel     (ref_sel)
  );

  assign target_free = !bank_busy[ref_bank] && path_idle && act_room[ref_rank];
  assign ref_fire    = rst_int_n && avail && target_free;

  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(ref_sel) && (ref_fire == (ref_sel != '0)));
  // R10
  sel_match_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ref_fire |-> ref_sel[ref_bank]);
  // R7
  rank_map_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    int'(ref_rank) == int'(ref_bank) / int'(BANKS_PER_RANK));
endmodule

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
  localparam int NR = 2, BPR = 4, NB = NR * BPR, PERIOD = 160;
  localparam int INTERVAL = PERIOD / NB, LIMIT = 10;

  logic          clk, rst_n, enable, path_idle;
  logic [NB-1:0] bank_busy, ref_sel;
  logic [NR-1:0] act_room;
  logic          ref_fire, overrun;
  logic [2:0]    ref_bank;
  logic [0:0]    ref_rank;

  refresh_sched #(.NUM_RANKS(NR), .BANKS_PER_RANK(BPR),
                  .REFRESH_PERIOD(PERIOD), .OVERRUN_LIMIT(LIMIT)) u_refresh_sched (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bank_busy(bank_busy),
    .path_idle(path_idle), .act_room(act_room), .ref_fire(ref_fire),
    .ref_bank(ref_bank), .ref_rank(ref_rank), .ref_sel(ref_sel), .overrun(overrun));

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int checks = 0, errors = 0;
  int m_cnt, m_pend, m_ptr;
  bit m_ovf, done = 0;
  int fires_seen;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_fire(input bit en, input int cnt, input int pend,
                                  input int ptr, input logic [NB-1:0] busy,
                                  input bit idle, input logic [NR-1:0] room);
    bit cr = en && (cnt == 1);
    return (pend != 0 || cr) && !busy[ptr] && idle && room[ptr / BPR];
  endfunction

  function automatic string fire_tag(input bit en, input int cnt, input int pend, input int ptr);
    if (!(pend != 0 || (en && cnt == 1))) return en ? "R2/R4" : "R3/R4";
    if (bank_busy[ptr]) return "R5";
    if (!path_idle) return "R6";
    if (!act_room[ptr / BPR]) return "R7";
    return "R2";
  endfunction

  // One cycle: inputs already driven; check outputs then advance the model.
  task automatic cycle();
    bit ef, cr;
    int np;
    #3;
    ef = exp_fire(enable, m_cnt, m_pend, m_ptr, bank_busy, path_idle, act_room);
    cr = enable && (m_cnt == 1);
    chk(ref_fire == ef, fire_tag(enable, m_cnt, m_pend, m_ptr), ref_fire, ef);
    if (ef) begin
      chk(ref_bank == 3'(m_ptr), "R8 pointer", ref_bank, m_ptr);
      chk(ref_rank == 1'(m_ptr / BPR), "R10 rank", ref_rank, m_ptr / BPR);
      chk(ref_sel == NB'(1) << m_ptr, "R10 select", ref_sel, 1 << m_ptr);
    end else begin
      chk(ref_sel == '0, "R10 select idle", ref_sel, 0);
    end
    chk(overrun == m_ovf, "R9 overrun", overrun, m_ovf);
    if (ref_fire) fires_seen++;
    @(posedge clk);
    if (enable) m_cnt = cr ? INTERVAL : m_cnt - 1;
    np = m_pend + int'(cr) - int'(ef);
    if (np >= LIMIT) begin np = LIMIT; m_ovf = 1; end
    m_pend = np;
    if (ef) m_ptr = (m_ptr == NB - 1) ? 0 : m_ptr + 1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1357));
    enable = 0; path_idle = 1; bank_busy = '0; act_room = '1; rst_n = 0;
    m_cnt = 1; m_pend = 0; m_ptr = 0; m_ovf = 0; fires_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state seen at the ports
    chk(ref_fire == 0 && ref_sel == '0, "R1 no strobe after reset", ref_fire, 0);
    chk(overrun == 0, "R1 overrun clear", overrun, 0);
    enable = 1;
    #3;
    chk(ref_fire == 1 && ref_bank == 0, "R1 first enabled cycle fires bank 0", ref_fire, 1);
    @(negedge clk);
    m_cnt = INTERVAL; m_pend = 0; m_ptr = 1;   // model the cycle just taken
    // R2 / R8: free running, pointer wraps
    fires_seen = 1;
    for (int i = 0; i < 12 * INTERVAL; i++) cycle();
    chk(fires_seen == 13, "R2 one strobe per interval", fires_seen, 13);
    // R3: frozen countdown with empty backlog
    enable = 0; fires_seen = 0;
    for (int i = 0; i < 5 * INTERVAL; i++) cycle();
    chk(fires_seen == 0, "R3 no strobe while disabled", fires_seen, 0);
    // R9: path blocked long enough to fill the backlog
    enable = 1; path_idle = 0;
    for (int i = 0; i < 12 * INTERVAL; i++) cycle();
    chk(overrun == 1, "R9 overrun raised", overrun, 1);
    // R3: backlog still drains while disabled
    enable = 0; path_idle = 1; fires_seen = 0;
    for (int i = 0; i < 20; i++) cycle();
    chk(fires_seen == LIMIT, "R3 backlog drains while disabled", fires_seen, LIMIT);
    chk(overrun == 1, "R9 overrun sticky", overrun, 1);
    // R5/R6/R7: random blocking patterns
    for (int i = 0; i < 4000; i++) begin
      enable    = ($urandom_range(9) != 0);
      path_idle = ($urandom_range(1) != 0);
      for (int b = 0; b < NB; b++) bank_busy[b] = ($urandom_range(3) == 0);
      for (int r = 0; r < NR; r++) act_room[r] = ($urandom_range(4) != 0);
      cycle();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule